// File: doc/BRIEF.md
# Four-Stage Pipeline Forwarding and Hazard Unit

This block decides how operands reach the ALU in a four-stage integer pipeline. Fetch, decode and control generation share the first stage (I). Register-file read and the ALU share the second stage (EX), and MEM and WB follow. Because operands are read in EX, the block compares the EX instruction's source indices with the destinations of the two older instructions in MEM and WB. A register value that has been computed but not yet written back is steered into the ALU through two operand multiplexers.

When the producer in MEM is a load, its data does not exist until the next cycle. The block then holds the PC and the I/EX register for one cycle and sends a bubble into EX/MEM. On the following cycle the load sits in WB and its result is forwarded from there. A branch or jump that resolves as taken in MEM clears the two younger pipeline registers, and this clear overrides any stall in the same cycle. The unit is purely combinational and feeds the datapath's multiplexer and register-enable controls directly.

Top module: `fwd_hazard4`

## Requirements
- R1: Each operand select uses the code 2'b00 for the register-file value, 2'b01 for the WB-stage result and 2'b10 for the MEM-stage ALU result. The code 2'b11 is never produced.
- R2: An operand whose source index equals the MEM destination selects 2'b10 when the MEM instruction writes a nonzero register and is not a load.
- R3: An operand with no such MEM match selects 2'b01 when its index equals the WB destination and the WB instruction writes a nonzero register.
- R4: When both MEM and WB qualify for the same operand, the MEM result (2'b10) wins.
- R5: A destination of register 0, or a producer whose write enable is low, never causes forwarding or a stall.
- R6: A load in MEM that writes a nonzero register matching either EX source causes `stall_hold`=1 and `exmem_clear`=1 with `iex_clear`=0 (absent a taken transfer). Once the load moves to WB, the consumer selects 2'b01.
- R7: `stall_hold` is 0 whenever no load-use match exists, including all dependencies that forwarding can satisfy.
- R8: A taken transfer in MEM drives `iex_clear`=1 and `exmem_clear`=1 and forces `stall_hold`=0.
- R9: A load in MEM never produces select 2'b10 for a matching operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | 5 | First source index of the EX instruction |
| ex_rs2 | input | 5 | Second source index of the EX instruction |
| mem_rd | input | 5 | Destination index of the MEM instruction |
| mem_wen | input | 1 | MEM instruction writes a register |
| mem_load | input | 1 | MEM instruction is a load |
| wb_rd | input | 5 | Destination index of the WB instruction |
| wb_wen | input | 1 | WB instruction writes a register |
| mem_taken | input | 1 | Control transfer in MEM resolved as taken |
| fwd_a | output | 2 | Operand A source select |
| fwd_b | output | 2 | Operand B source select |
| stall_hold | output | 1 | Hold the PC and the I/EX register |
| iex_clear | output | 1 | Clear the I/EX register |
| exmem_clear | output | 1 | Clear EX/MEM (bubble or flush) |

## Verification
The block holds no state, so any fault shows on the outputs in the same cycle as the input pattern that exposes it. A wrong priority or a wrong qualifier appears as a select code that differs from the model for a single combination of matching indices. The bench therefore aims its stimulus at index collisions, loads to register 0 and taken transfers that coincide with load-use matches. A wrong stall shows up as `stall_hold` or `exmem_clear` disagreeing with the model on the very cycle the load sits in MEM.

// File: rtl/fwd_hazard4.sv
module fwd_hazard4 #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  input  logic          mem_taken,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall_hold,
  output logic          iex_clear,
  output logic          exmem_clear
);
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;

  logic mem_live, wb_live, load_use;

  assign mem_live = mem_wen && (mem_rd != '0);
  assign wb_live  = wb_wen && (wb_rd != '0);

  function automatic logic [1:0] pick(input logic [AW-1:0] rs, input logic m_ok,
                                      input logic w_ok);
    if (m_ok && rs == mem_rd)     return SEL_MEM;
    else if (w_ok && rs == wb_rd) return SEL_WB;
    else                          return SEL_RF;
  endfunction

  assign fwd_a = pick(ex_rs1, mem_live && !mem_load, wb_live);
  assign fwd_b = pick(ex_rs2, mem_live && !mem_load, wb_live);

  assign load_use    = mem_live && mem_load && (ex_rs1 == mem_rd || ex_rs2 == mem_rd);
  assign stall_hold  = load_use && !mem_taken;
  assign iex_clear   = mem_taken;
  assign exmem_clear = load_use || mem_taken;

  always_comb begin
    assert_sel_code_R1: assert (fwd_a != 2'b11 && fwd_b != 2'b11)
      else $error("select code 11");
    assert_mem_src_R2: assert (fwd_a != SEL_MEM || (mem_wen && mem_rd == ex_rs1 && mem_rd != '0))
      else $error("operand A taken from MEM without a match");
    assert_wb_src_R3: assert (fwd_b != SEL_WB || (wb_wen && wb_rd == ex_rs2 && wb_rd != '0))
      else $error("operand B taken from WB without a match");
    assert_zero_dest_R5: assert (!(stall_hold && mem_rd == '0))
      else $error("stall on register 0");
    assert_stall_load_R7: assert (!stall_hold || mem_load)
      else $error("stall without a load in MEM");
    assert_flush_wins_R8: assert (!(mem_taken && stall_hold))
      else $error("stall during flush");
    assert_no_load_fwd_R9: assert (!(mem_load && (fwd_a == SEL_MEM || fwd_b == SEL_MEM)))
      else $error("load forwarded from MEM");
  end
endmodule

// File: tb/fwd_hazard4_bench.sv
module fwd_hazard4_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [4:0] ex_rs1 = 0, ex_rs2 = 0, mem_rd = 0, wb_rd = 0;
  logic mem_wen = 0, mem_load = 0, wb_wen = 0, mem_taken = 0;
  logic [1:0] fwd_a, fwd_b;
  logic stall_hold, iex_clear, exmem_clear;
  int checks = 0, errors = 0;
  bit done = 0;

  fwd_hazard4 u_fwd_hazard4 (
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .mem_rd(mem_rd), .mem_wen(mem_wen),
    .mem_load(mem_load), .wb_rd(wb_rd), .wb_wen(wb_wen), .mem_taken(mem_taken),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall_hold(stall_hold),
    .iex_clear(iex_clear), .exmem_clear(exmem_clear));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int want_sel(int rs);
    bit m = mem_wen && mem_rd != 0 && !mem_load;
    bit w = wb_wen && wb_rd != 0;
    if (m && rs == int'(mem_rd)) return 2;
    if (w && rs == int'(wb_rd)) return 1;
    return 0;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    bit lu = mem_wen && mem_rd != 0 && mem_load && (ex_rs1 == mem_rd || ex_rs2 == mem_rd);
    cmp(tag, "fwd_a", int'(fwd_a), want_sel(int'(ex_rs1)));
    cmp(tag, "fwd_b", int'(fwd_b), want_sel(int'(ex_rs2)));
    cmp(tag, "stall_hold", int'(stall_hold), int'(lu && !mem_taken));
    cmp(tag, "iex_clear", int'(iex_clear), int'(mem_taken));
    cmp(tag, "exmem_clear", int'(exmem_clear), int'(lu || mem_taken));
  endtask

  task automatic step(string tag, int r1, int r2, int mr, bit mw, bit ml,
                      int wr, bit ww, bit tk);
    @(posedge clk); #1;
    ex_rs1 = 5'(r1); ex_rs2 = 5'(r2); mem_rd = 5'(mr); mem_wen = mw;
    mem_load = ml; wb_rd = 5'(wr); wb_wen = ww; mem_taken = tk;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1");
    step("R2", 5, 1, 5, 1, 0, 0, 0, 0);
    step("R3", 1, 7, 2, 1, 0, 7, 1, 0);
    step("R4", 3, 3, 3, 1, 0, 3, 1, 0);
    step("R5", 0, 0, 0, 1, 1, 0, 1, 0);
    step("R5", 8, 8, 8, 0, 1, 8, 0, 0);
    step("R6", 2, 9, 9, 1, 1, 4, 1, 0);
    step("R9", 9, 9, 9, 1, 1, 9, 1, 0);
    step("R6", 2, 9, 3, 1, 0, 9, 1, 0);
    step("R7", 4, 6, 9, 1, 1, 6, 1, 0);
    step("R7", 9, 9, 9, 1, 0, 0, 0, 0);
    step("R8", 9, 1, 9, 1, 1, 0, 0, 1);
    step("R8", 1, 2, 3, 0, 0, 4, 0, 1);
    for (int i = 0; i < 3000; i++)
      step("R1_R2_R3_R4_R5_R6_R7_R8_R9",
           int'($urandom_range(0, 4)), int'($urandom_range(0, 4)),
           int'($urandom_range(0, 4)), 1'($urandom), 1'($urandom),
           int'($urandom_range(0, 4)), 1'($urandom), 1'($urandom_range(0, 5) == 0));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule